// File: doc/BRIEF.md
# Console Transmit Peripheral

A small bus-mapped output port for a processor console. Software writes a character into the data register. The block holds it in a single transmit slot and offers it on a byte stream with valid/ready handshaking toward the host link. Once the byte has left, the block reports free space again and can raise an interrupt so that software knows it may send the next character.

The control register holds a read-interrupt enable (bit 0), a write-interrupt enable (bit 1), a spare software flag (bit 10), a read-interrupt pending bit (bit 8, always zero), a write-interrupt pending bit (bit 9) and a 16-bit free-space count in bits 31:16. Each register masks the bits it implements, and software can change only some of them. The interrupt line is held low for a fixed number of cycles after reset, and after that it follows the enable and the space count. There is no receive path.

Top module: `con_tx`

## Requirements
- R1: After reset the control register reads `TX_CAP` in bits 31:16 and zero in every other bit. The data register reads zero, `tx_valid_o` is low and `irq_o` is low.
- R2: Only byte addresses 0 (data) and 4 (control) are claimed. A read returns its word on `rdata_o`, with `hit_o` high, in the cycle after the address is presented. Any other address gives `hit_o` low and `rdata_o` zero, and a write to it changes nothing.
- R3: A write to address 0 with byte enable 0 set, made while the slot is free, loads `wdata_i[7:0]` into the slot. The byte appears on `tx_data_o` with `tx_valid_o` high after the next edge. The same write zeroes the space count and clears the write-interrupt pending bit. A data write without byte enable 0 queues nothing. Reads of the data register return the last accepted byte in bits 7:0 and zero in bits 31:8.
- R4: In the control register, software can write only bit 0 and bit 1 (byte lane 0) and bit 10 (byte lane 1). Writes to every other bit are ignored, and bits 2 to 7 and 11 to 15 always read zero.
- R5: A byte leaves only in a cycle where `tx_valid_o` and `tx_ready_i` are both high. While `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` hold their values.
- R6: After a byte leaves with no new byte accepted in the same cycle, the slot is empty and the space count reads `TX_CAP`.
- R7: A data write made while the slot is occupied and the byte is not leaving in that cycle is dropped, and the held byte is unchanged.
- R8: A data write in the same cycle as a departing byte is accepted. The new byte occupies the slot, the space count stays zero and the write-interrupt pending bit is cleared.
- R9: The write-interrupt pending bit is set at the next edge when the write-interrupt enable is on and either a byte is leaving, or the slot is empty and the space count is nonzero.
- R10: A control write whose lane-0 data has bit 0 or bit 1 set clears the write-interrupt pending bit at that edge. The rule of R9 may set it again one cycle later.
- R11: `irq_o` stays low for the first `IRQ_DELAY` clock edges after reset. From then on it is high exactly when the write-interrupt enable is set and the space count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| be_i | input | 4 | Byte-lane enables for the write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the address |
| hit_o | output | 1 | The previous cycle's address was claimed |
| tx_data_o | output | 8 | Outgoing byte |
| tx_valid_o | output | 1 | Outgoing byte is valid |
| tx_ready_i | input | 1 | Host link accepts the byte |
| irq_o | output | 1 | Write-space interrupt request |

## Verification
The key collision is a data-register write landing on the same edge as a byte leaving on the stream. Freeing the slot and refilling it then happen at once, and they disagree on the space count and on the pending bit. The bench forces this by holding `tx_ready_i` low to keep a byte waiting, then raising ready in the very cycle it writes a new byte. It then judges the result: the new byte must be on the output, and a following control read must show zero space and no pending write interrupt. Randomized traffic reaches the same collision, and a control write that clears the pending bit can also fall on a departure.

// File: rtl/con_tx_pkg.sv
package con_tx_pkg;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;
  localparam int OFF_DATA = 0;
  localparam int OFF_CTRL = 4;

  // control bit positions
  localparam int RIE_B  = 0;
  localparam int WIE_B  = 1;
  localparam int RIP_B  = 8;
  localparam int WIP_B  = 9;
  localparam int AUX_B  = 10;
  localparam int SPC_LSB = 16;
  localparam int SPC_W  = 16;

  // implemented / read-only masks
  localparam logic [BUS_W-1:0] DATA_IMPL = 32'hFFFF_80FF;
  localparam logic [BUS_W-1:0] DATA_RO   = 32'hFFFF_8000;
  localparam logic [BUS_W-1:0] CTRL_IMPL = 32'hFFFF_0703;
  localparam logic [BUS_W-1:0] CTRL_RO   = 32'hFFFF_0300;
  localparam logic [BUS_W-1:0] DATA_SW   = DATA_IMPL & ~DATA_RO;
  localparam logic [BUS_W-1:0] CTRL_SW   = CTRL_IMPL & ~CTRL_RO;
endpackage

// File: rtl/con_tx_regs.sv
module con_tx_regs
  import con_tx_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [7:0]        slot_byte_i,
  input  logic [SPC_W-1:0]  space_i,
  input  logic              wip_i,
  output logic              data_wr_o,
  output logic              ctrl_clr_o,
  output logic [BUS_W-1:0]  ctrl_sw_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  logic             sel_d, sel_c;
  logic [BUS_W-1:0] lane_m, ctrl_m;
  logic [BUS_W-1:0] ctrl_q;
  logic [BUS_W-1:0] rd_data, rd_ctrl;
  logic [BUS_W-1:0] rdata_q;
  logic             hit_q;

  assign sel_d = (addr_i == A_DATA);
  assign sel_c = (addr_i == A_CTRL);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_m[l*8 +: 8] = {8{be_i[l]}};
  end

  assign ctrl_m     = CTRL_SW & lane_m;
  assign data_wr_o  = we_i & sel_d & (|(DATA_SW & lane_m));
  assign ctrl_clr_o = we_i & sel_c & be_i[0] & (wdata_i[RIE_B] | wdata_i[WIE_B]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ctrl_q <= '0;
    else if (we_i && sel_c)  ctrl_q <= (ctrl_q & ~ctrl_m) | (wdata_i & ctrl_m);
  end

  assign ctrl_sw_o = ctrl_q;

  always_comb begin
    rd_data = {{(BUS_W-8){1'b0}}, slot_byte_i} & DATA_IMPL;
    rd_ctrl = ctrl_q & CTRL_SW;
    rd_ctrl[SPC_LSB +: SPC_W] = space_i;
    rd_ctrl[WIP_B] = wip_i;
    rd_ctrl[RIP_B] = 1'b0;
    rd_ctrl = rd_ctrl & CTRL_IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      hit_q   <= sel_d | sel_c;
      rdata_q <= sel_d ? rd_data : (sel_c ? rd_ctrl : '0);
    end
  end

  assign rdata_o = rdata_q;
  assign hit_o   = hit_q;
endmodule

// File: rtl/con_tx_slot.sv
module con_tx_slot (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic [7:0] push_byte_i,
  input  logic       ready_i,
  output logic       valid_o,
  output logic [7:0] byte_o,
  output logic       fire_o,
  output logic       accept_o
);
  logic       full_q;
  logic [7:0] byte_q;

  assign fire_o   = full_q & ready_i;
  // a departing byte frees the slot for a write in the same cycle
  assign accept_o = push_i & (~full_q | fire_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      byte_q <= '0;
    end else begin
      if (accept_o)     full_q <= 1'b1;
      else if (fire_o)  full_q <= 1'b0;
      if (accept_o)     byte_q <= push_byte_i;
    end
  end

  assign valid_o = full_q;
  assign byte_o  = byte_q;
endmodule

// File: rtl/con_tx_irq.sv
module con_tx_irq
  import con_tx_pkg::*;
#(
  parameter int TX_CAP    = 1,
  parameter int IRQ_DELAY = 500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             fire_i,
  input  logic             full_i,
  input  logic             ctrl_clr_i,
  input  logic             wie_i,
  output logic [SPC_W-1:0] space_o,
  output logic             wip_o,
  output logic             irq_o
);
  localparam int DLY_W = $clog2(IRQ_DELAY + 1);
  localparam logic [SPC_W-1:0] CAP_V = SPC_W'(TX_CAP);
  localparam logic [DLY_W-1:0] DLY_V = DLY_W'(IRQ_DELAY);

  logic [SPC_W-1:0] space_q;
  logic             wip_q, wip_d;
  logic [DLY_W-1:0] dly_q;

  always_comb begin
    wip_d = wip_q;
    if (wie_i && (fire_i || (!full_i && space_q != '0))) wip_d = 1'b1;
    if (ctrl_clr_i) wip_d = 1'b0;
    if (accept_i)   wip_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      space_q <= CAP_V;
      wip_q   <= 1'b0;
      dly_q   <= DLY_V;
    end else begin
      wip_q <= wip_d;
      if (accept_i)    space_q <= '0;
      else if (fire_i) space_q <= CAP_V;
      if (dly_q != '0) dly_q <= dly_q - 1'b1;
    end
  end

  assign space_o = space_q;
  assign wip_o   = wip_q;
  assign irq_o   = (dly_q == '0) & wie_i & (space_q != '0);
endmodule

// File: rtl/con_tx.sv
module con_tx
  import con_tx_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int TX_CAP    = 1,
  parameter int IRQ_DELAY = 500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              hit_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  logic             data_wr, ctrl_clr, fire, accept;
  logic [BUS_W-1:0] ctrl_sw;
  logic [SPC_W-1:0] wspace;
  logic             wip, wie;

  assign wie = ctrl_sw[WIE_B];

  con_tx_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .we_i        (we_i),
    .be_i        (be_i),
    .wdata_i     (wdata_i),
    .slot_byte_i (tx_data_o),
    .space_i     (wspace),
    .wip_i       (wip),
    .data_wr_o   (data_wr),
    .ctrl_clr_o  (ctrl_clr),
    .ctrl_sw_o   (ctrl_sw),
    .rdata_o     (rdata_o),
    .hit_o       (hit_o)
  );

  con_tx_slot u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (data_wr),
    .push_byte_i (wdata_i[7:0]),
    .ready_i     (tx_ready_i),
    .valid_o     (tx_valid_o),
    .byte_o      (tx_data_o),
    .fire_o      (fire),
    .accept_o    (accept)
  );

  con_tx_irq #(.TX_CAP(TX_CAP), .IRQ_DELAY(IRQ_DELAY)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .fire_i     (fire),
    .full_i     (tx_valid_o),
    .ctrl_clr_i (ctrl_clr),
    .wie_i      (wie),
    .space_o    (wspace),
    .wip_o      (wip),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/con_tx_chk.sv
module con_tx_chk
  import con_tx_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int TX_CAP    = 1,
  parameter int IRQ_DELAY = 500
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [3:0]        be_i,
  input logic [31:0]       wdata_i,
  input logic [7:0]        tx_data_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic              irq_o,
  input logic [SPC_W-1:0]  wspace,
  input logic              wie,
  input logic [BUS_W-1:0]  ctrl_sw
);
  localparam int CW = $clog2(IRQ_DELAY + 1);
  localparam logic [CW-1:0] DLY_V = CW'(IRQ_DELAY);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  logic [CW-1:0] cyc_q;
  logic          push;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cyc_q <= '0;
    else if (cyc_q != DLY_V) cyc_q <= cyc_q + 1'b1;
  end

  assign push = we_i && addr_i == A_DATA && be_i[0] && (!tx_valid_o || tx_ready_i);

  p_unclaimed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != A_DATA && addr_i != A_CTRL) |=> $stable(ctrl_sw));

  p_push_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> (tx_valid_o && tx_data_o == $past(wdata_i[7:0]) && wspace == '0));

  p_ro_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_sw & ~CTRL_SW) == '0);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> tx_valid_o);

  p_send_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && !push) |=> (!tx_valid_o && wspace == SPC_W'(TX_CAP)));

  p_keep_byte_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> $stable(tx_data_o));

  p_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cyc_q == DLY_V));

  p_irq_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (wie && wspace != '0));
endmodule

bind con_tx con_tx_chk #(
  .ADDR_W(ADDR_W), .TX_CAP(TX_CAP), .IRQ_DELAY(IRQ_DELAY)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .be_i       (be_i),
  .wdata_i    (wdata_i),
  .tx_data_o  (tx_data_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .irq_o      (irq_o),
  .wspace     (wspace),
  .wie        (wie),
  .ctrl_sw    (ctrl_sw)
);

// File: tb/con_tx_bench.sv
module con_tx_bench;
  localparam int ADDR_W = 4;
  localparam int TX_CAP = 1;
  localparam int IRQ_DELAY = 500;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              we_i = 1'b0;
  logic [3:0]        be_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              hit_o;
  logic [7:0]        tx_data_o;
  logic              tx_valid_o;
  logic              tx_ready_i = 1'b0;
  logic              irq_o;

  always #10 clk_i = ~clk_i;

  con_tx #(.ADDR_W(ADDR_W), .TX_CAP(TX_CAP), .IRQ_DELAY(IRQ_DELAY)) u_con_tx (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  bit        m_full, m_rie, m_wie, m_aux, m_wip, m_hit;
  bit [7:0]  m_byte;
  bit [15:0] m_space;
  int        m_cnt;
  bit [31:0] m_rdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] ctrl_word();
    return {m_space, 5'b0, m_aux, m_wip, 1'b0, 6'b0, m_wie, m_rie};
  endfunction

  task automatic compare();
    chk(tx_valid_o === m_full, "R5 tx_valid", 32'(tx_valid_o), 32'(m_full));
    if (m_full) chk(tx_data_o === m_byte, "R3 tx_data", 32'(tx_data_o), 32'(m_byte));
    chk(irq_o === (m_cnt == 0 && m_wie && m_space != 0), "R11 irq", 32'(irq_o),
        32'(m_cnt == 0 && m_wie && m_space != 0));
    chk(hit_o === m_hit, "R2 hit", 32'(hit_o), 32'(m_hit));
    chk(rdata_o === m_rdata, "R4 rdata", rdata_o, m_rdata);
  endtask

  // one cycle: drive, predict, clock, compare
  task automatic step(input logic [ADDR_W-1:0] a, input bit w, input logic [3:0] b,
                      input logic [31:0] d, input bit rdy);
    bit fire, dsel, csel, acc, wip_n;
    addr_i = a; we_i = w; be_i = b; wdata_i = d; tx_ready_i = rdy;
    fire = m_full && rdy;
    dsel = w && a == 0 && b[0];
    csel = w && a == 4;
    acc  = dsel && (!m_full || fire);
    wip_n = m_wip;
    if (m_wie && (fire || (!m_full && m_space != 0))) wip_n = 1;
    if (csel && b[0] && (d[0] || d[1])) wip_n = 0;
    if (acc) wip_n = 0;
    @(posedge clk_i);
    m_hit   = (a == 0 || a == 4);
    m_rdata = (a == 0) ? {24'b0, m_byte} : (a == 4) ? ctrl_word() : 32'b0;
    m_wip = wip_n;
    if (acc) begin m_space = 0; m_byte = d[7:0]; m_full = 1; end
    else if (fire) begin m_space = 16'(TX_CAP); m_full = 0; end
    if (csel && b[0]) begin m_rie = d[0]; m_wie = d[1]; end
    if (csel && b[1]) m_aux = d[10];
    if (m_cnt > 0) m_cnt--;
    @(negedge clk_i);
    compare();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(2024);
    m_full = 0; m_rie = 0; m_wie = 0; m_aux = 0; m_wip = 0; m_hit = 0;
    m_byte = 0; m_space = 16'(TX_CAP); m_cnt = IRQ_DELAY; m_rdata = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk(tx_valid_o === 1'b0, "R1 valid after reset", 32'(tx_valid_o), 0);
    chk(irq_o === 1'b0, "R1 irq after reset", 32'(irq_o), 0);
    step(4, 0, 0, 0, 0);
    chk(rdata_o === (32'(TX_CAP) << 16), "R1 control reset", rdata_o, 32'(TX_CAP) << 16);
    step(0, 0, 0, 0, 0);
    chk(rdata_o === 32'h0, "R1 data reset", rdata_o, 0);

    // enable write interrupt, pending should rise (R9)
    step(4, 1, 4'b0001, 32'h2, 0);
    step(4, 0, 0, 0, 0);
    step(4, 0, 0, 0, 0);
    chk(rdata_o[9] === 1'b1, "R9 pending set when empty", 32'(rdata_o[9]), 1);

    // R11 start-up hold-off
    while (m_cnt > 1) step(4, 0, 0, 0, 0);
    chk(irq_o === 1'b0, "R11 irq held before delay", 32'(irq_o), 0);
    step(4, 0, 0, 0, 0);
    chk(irq_o === 1'b1, "R11 irq after delay", 32'(irq_o), 1);

    // R10 control write clears pending, rule sets it again a cycle later
    step(4, 1, 4'b0001, 32'h2, 0);
    step(4, 0, 0, 0, 0);
    chk(rdata_o[9] === 1'b0, "R10 pending cleared", 32'(rdata_o[9]), 0);
    step(4, 0, 0, 0, 0);
    chk(rdata_o[9] === 1'b1, "R10 pending re-set", 32'(rdata_o[9]), 1);

    // R4 masking
    step(4, 1, 4'hF, 32'hFFFF_FFFF, 0);
    step(4, 0, 0, 0, 0);
    chk((rdata_o & 32'h0000_F8FC) === 32'h0, "R4 read-only bits zero", rdata_o, rdata_o & ~32'h0000_F8FC);
    chk(rdata_o[16 +: 16] === 16'(TX_CAP), "R4 space not writable", 32'(rdata_o[31:16]), TX_CAP);
    chk(rdata_o[10] === 1'b1, "R4 bit10 written", 32'(rdata_o[10]), 1);
    step(4, 1, 4'b0010, 32'h0, 0);
    step(4, 0, 0, 0, 0);
    chk(rdata_o[10] === 1'b0 && rdata_o[1:0] === 2'b11, "R4 lane 1 only", rdata_o, 32'h3);
    step(4, 1, 4'b0001, 32'h2, 0);

    // R3 queue, R7 drop, R5/R6 send
    step(0, 1, 4'b1110, 32'h55, 0);
    chk(tx_valid_o === 1'b0, "R3 no lane0 no queue", 32'(tx_valid_o), 0);
    step(0, 1, 4'b0001, 32'hFFFF_01A5, 0);
    chk(tx_valid_o === 1'b1 && tx_data_o === 8'hA5, "R3 byte queued", 32'(tx_data_o), 32'hA5);
    step(0, 0, 0, 0, 0);
    chk(rdata_o === 32'h0000_00A5, "R3 data readback", rdata_o, 32'hA5);
    step(4, 0, 0, 0, 0);
    chk(rdata_o[31:16] === 16'h0 && rdata_o[9] === 1'b0, "R3 space and pending cleared", rdata_o, 32'h2);
    step(0, 1, 4'b0001, 32'h3C, 0);
    chk(tx_data_o === 8'hA5, "R7 write dropped", 32'(tx_data_o), 32'hA5);
    step(4, 0, 0, 0, 1);
    chk(tx_valid_o === 1'b0, "R5 byte left", 32'(tx_valid_o), 0);
    step(4, 0, 0, 0, 0);
    chk(rdata_o[31:16] === 16'(TX_CAP), "R6 space restored", 32'(rdata_o[31:16]), TX_CAP);

    // R8 collision of write and departure
    step(0, 1, 4'b0001, 32'h11, 0);
    step(0, 1, 4'b0001, 32'h22, 1);
    chk(tx_valid_o === 1'b1 && tx_data_o === 8'h22, "R8 refill on departure", 32'(tx_data_o), 32'h22);
    step(4, 0, 0, 0, 0);
    chk(rdata_o[31:16] === 16'h0 && rdata_o[9] === 1'b0, "R8 space zero pending clear", rdata_o, 32'h2);
    step(4, 0, 0, 0, 1);

    // R2 unclaimed addresses
    step(8, 1, 4'hF, 32'hFFFF_FFFF, 0);
    chk(hit_o === 1'b0 && rdata_o === 32'h0, "R2 unclaimed read", rdata_o, 0);
    step(4, 0, 0, 0, 0);
    chk(rdata_o[10] === 1'b0 && rdata_o[0] === 1'b0, "R2 write ignored", rdata_o, 32'h0);

    // randomized traffic
    for (int i = 0; i < 4000; i++) begin
      logic [ADDR_W-1:0] a;
      case ($urandom % 5)
        0: a = 0;
        1: a = 4;
        2: a = 8;
        3: a = 2;
        default: a = 12;
      endcase
      step(a, ($urandom % 5) < 2, 4'($urandom), $urandom, ($urandom % 2) == 1);
    end
    finish_run();
  end
endmodule